// File: doc/BRIEF.md
# Flash Page Latch Loader

This block is a small system-call engine that fills a 64-byte flash page latch from a parameter block held in word-addressed SRAM. Software first stores the byte address of the parameter block in an argument register. It then writes a function code, with the call bit set, into a request register. The engine reads the header words over a simple SRAM read port and validates the two key bytes, the start offset, the macro number and the byte count. It then streams the data words and places up to four bytes per cycle into the latch.

When the call finishes, the engine writes a 4-bit status code into the top nibble of the argument register and clears the call bit in the request register. The latch keeps its contents across calls. It is wiped only by a clear input, which the flash program logic outside this block pulses when a page has been programmed. A separate combinational read port exposes any latch byte. Another output reports the macro number of the last successful load.

Top module: `flash_latch_loader`

## Requirements
- R1: A write to the request register (`reg_wr_sel`=1) with bit 31 set, while the engine is idle, starts a call, and `busy` is high from the next cycle.
- R2: Only function code 0x0004 in request bits [15:0] performs a load. Any other code ends the call with status 0x1 after one busy cycle and no SRAM read.
- R3: An argument register value whose bits [1:0] are not zero ends the call with status 0x3 after one busy cycle and no SRAM read. This check follows the function-code check.
- R4: In the header word at the base address, bits [7:0] must be 0xB6 and bits [15:8] must be 0xD7. Otherwise the status is 0x2.
- R5: Header bits [31:24] select the macro and must be 0 or 1. A larger value gives status 0x4. A successful call copies the macro number to `latch_macro`.
- R6: Header bits [23:16] hold the start offset. Bits [7:0] of the word at base+4 hold the byte count minus one, and its upper 24 bits are ignored. If offset plus count exceeds 64, the status is 0x5. When several header checks fail, the key error (0x2) is reported first, then the macro error (0x4), then the range error (0x5).
- R7: Data bytes start at base+8, little-endian within each word. Data byte k lands in latch byte offset+k, and every other latch byte keeps its value.
- R8: On completion, the argument register becomes {status, 28'h0}, with status 0xA for success. A failed call leaves the latch untouched.
- R9: On completion, request bit 31 is cleared and request bits [30:0] keep their value.
- R10: While `busy` is high, writes to either register are ignored.
- R11: `latch_clr` sets all 64 latch bytes to zero. Without it, latch contents persist across calls.
- R12: `busy` lasts 1 cycle for an R2 or R3 rejection, 3 cycles for a header failure, and 4+ceil(count/4) cycles for a successful load.
- R13: The engine issues at most one SRAM read per cycle, only while busy, always at a word-aligned address. Read data is taken one cycle after the request. A call makes 0 reads when rejected, 2 on a header failure, and 2+ceil(count/4) on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the argument register, 1 selects the request register |
| reg_wr_data | input | 32 | Register write data |
| arg_q | output | 32 | Argument register: base address in, status out |
| req_q | output | 32 | Request register: function code and call bit |
| busy | output | 1 | Call in progress |
| sram_rd_en | output | 1 | SRAM read request |
| sram_rd_addr | output | 32 | SRAM byte address, word aligned |
| sram_rd_data | input | 32 | SRAM read data, valid one cycle after the request |
| latch_clr | input | 1 | Clears the whole page latch (program operation done) |
| latch_rd_idx | input | 6 | Latch byte index for the read port |
| latch_rd_data | output | 8 | Latch byte at `latch_rd_idx` |
| latch_macro | output | 1 | Macro number of the last successful load |

## Verification
The bench targets the range edge at the end of the latch, where an offset of 60 with four bytes must pass and an offset of 61 with four bytes must fail. A design with an off-by-one range check either drops a legal load or writes past the last byte. Single-byte and full 64-byte loads exercise the partial last word; a wrong lane mask would corrupt the latch byte that follows the last copied byte. Headers with more than one fault check the order of the error codes, and a count byte above 0x3F checks that the upper bits of the size are not silently discarded. Register writes during a long call, together with a clear followed by a reload, show whether the design lets software disturb a running call or loses latch contents between calls.

// File: rtl/fll_pkg.sv
package fll_pkg;
   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / 8;

   localparam logic [3:0] STAT_OK    = 4'hA;
   localparam logic [3:0] STAT_OPC   = 4'h1;
   localparam logic [3:0] STAT_KEY   = 4'h2;
   localparam logic [3:0] STAT_ALIGN = 4'h3;
   localparam logic [3:0] STAT_MACRO = 4'h4;
   localparam logic [3:0] STAT_RANGE = 4'h5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REJ,
      ST_HDR0,
      ST_HDR1,
      ST_SIZE,
      ST_DATA
   } fll_state_e;
endpackage

// File: rtl/fll_regs.sv
module fll_regs
   import fll_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              busy,
   input  logic              done,
   input  logic [3:0]        done_code,
   output logic [WORD_W-1:0] arg_q,
   output logic [WORD_W-1:0] req_q,
   output logic              start_o,
   output logic [15:0]       opcode_o
);
   localparam int CALL_BIT = WORD_W - 1;

   assign start_o  = wr_en && wr_sel && wr_data[CALL_BIT] && !busy;
   assign opcode_o = wr_data[15:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arg_q <= '0;
         req_q <= '0;
      end else if (done) begin
         arg_q           <= {done_code, {(WORD_W-4){1'b0}}};
         req_q[CALL_BIT] <= 1'b0;
      end else if (wr_en && !busy) begin
         if (wr_sel) req_q <= wr_data;
         else        arg_q <= wr_data;
      end
   end
endmodule

// File: rtl/fll_seq.sv
module fll_seq
   import fll_pkg::*;
#(
   parameter int          LATCH_BYTES = 64,
   parameter int          N_MACRO     = 2,
   parameter logic [15:0] OPCODE      = 16'h0004,
   parameter logic [7:0]  KEY_LO      = 8'hB6,
   parameter logic [7:0]  KEY_HI      = 8'hD7,
   localparam int LAT_AW  = $clog2(LATCH_BYTES),
   localparam int MSEL_W  = (N_MACRO > 1) ? $clog2(N_MACRO) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [15:0]       opcode_i,
   input  logic [WORD_W-1:0] base_i,
   output logic              rd_en_o,
   output logic [WORD_W-1:0] rd_addr_o,
   input  logic [WORD_W-1:0] rd_data_i,
   output logic [LANES-1:0]  wr_lane_o,
   output logic [LAT_AW-1:0] wr_pos_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic              done_o,
   output logic [3:0]        code_o,
   output logic              ok_o,
   output logic [MSEL_W-1:0] macro_o,
   output logic              busy_o
);
   localparam int CNT_W   = LAT_AW + 1;
   localparam int WORDS_W = $clog2(LATCH_BYTES / LANES) + 1;

   fll_state_e         state_q;
   logic [WORD_W-1:0]  base_q, ptr_q;
   logic [3:0]         code_q;
   logic               key_ok_q, vld_q;
   logic [7:0]         off_q, macro_q;
   logic [CNT_W-1:0]   left_q;
   logic [WORDS_W-1:0] issue_q;
   logic [LAT_AW-1:0]  pos_q;

   logic [8:0]         size_cnt;
   logic [9:0]         span;
   logic [3:0]         hdr_code;
   logic               last;
   logic [2:0]         take;

   assign size_cnt = {1'b0, rd_data_i[7:0]} + 9'd1;
   assign span     = {2'b00, off_q} + {1'b0, size_cnt};

   always_comb begin
      if (!key_ok_q)                       hdr_code = STAT_KEY;
      else if (macro_q >= 8'(N_MACRO))     hdr_code = STAT_MACRO;
      else if (span > 10'(LATCH_BYTES))    hdr_code = STAT_RANGE;
      else                                 hdr_code = STAT_OK;
   end

   assign last = left_q <= CNT_W'(LANES);
   assign take = last ? left_q[2:0] : 3'(LANES);

   always_comb begin
      for (int l = 0; l < LANES; l++) wr_lane_o[l] = vld_q && (3'(l) < take);
   end
   assign wr_pos_o  = pos_q;
   assign wr_data_o = rd_data_i;

   always_comb begin
      rd_en_o   = 1'b0;
      rd_addr_o = ptr_q;
      case (state_q)
         ST_HDR0: begin rd_en_o = 1'b1; rd_addr_o = base_q; end
         ST_HDR1: begin rd_en_o = 1'b1; rd_addr_o = base_q + WORD_W'(4); end
         ST_DATA: rd_en_o = (issue_q != '0);
         default: ;
      endcase
   end

   always_comb begin
      done_o = 1'b0;
      ok_o   = 1'b0;
      code_o = STAT_OK;
      case (state_q)
         ST_REJ:  begin done_o = 1'b1; code_o = code_q; end
         ST_SIZE: begin done_o = (hdr_code != STAT_OK); code_o = hdr_code; end
         ST_DATA: begin done_o = vld_q && last; ok_o = vld_q && last; end
         default: ;
      endcase
   end

   assign busy_o  = (state_q != ST_IDLE);
   assign macro_o = macro_q[MSEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         base_q   <= '0;
         ptr_q    <= '0;
         code_q   <= STAT_OK;
         key_ok_q <= 1'b0;
         vld_q    <= 1'b0;
         off_q    <= '0;
         macro_q  <= '0;
         left_q   <= '0;
         issue_q  <= '0;
         pos_q    <= '0;
      end else begin
         vld_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               base_q <= base_i;
               if (opcode_i != OPCODE) begin
                  code_q  <= STAT_OPC;
                  state_q <= ST_REJ;
               end else if (base_i[1:0] != 2'b00) begin
                  code_q  <= STAT_ALIGN;
                  state_q <= ST_REJ;
               end else begin
                  state_q <= ST_HDR0;
               end
            end
            ST_REJ:  state_q <= ST_IDLE;
            ST_HDR0: state_q <= ST_HDR1;
            ST_HDR1: begin
               key_ok_q <= (rd_data_i[7:0] == KEY_LO) && (rd_data_i[15:8] == KEY_HI);
               off_q    <= rd_data_i[23:16];
               macro_q  <= rd_data_i[31:24];
               state_q  <= ST_SIZE;
            end
            ST_SIZE: begin
               if (hdr_code != STAT_OK) begin
                  state_q <= ST_IDLE;
               end else begin
                  left_q  <= CNT_W'(size_cnt);
                  issue_q <= WORDS_W'((size_cnt + 9'd3) >> 2);
                  ptr_q   <= base_q + WORD_W'(8);
                  pos_q   <= off_q[LAT_AW-1:0];
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (issue_q != '0) begin
                  ptr_q   <= ptr_q + WORD_W'(4);
                  issue_q <= issue_q - WORDS_W'(1);
               end
               vld_q <= (issue_q != '0);
               if (vld_q) begin
                  pos_q  <= pos_q + LAT_AW'(LANES);
                  left_q <= left_q - CNT_W'(take);
                  if (last) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fll_latch.sv
module fll_latch
   import fll_pkg::*;
#(
   parameter int LATCH_BYTES    = 64,
   parameter bit RESET_CONTENTS = 1'b1,
   localparam int LAT_AW = $clog2(LATCH_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [LANES-1:0]  lane_en,
   input  logic [LAT_AW-1:0] pos,
   input  logic [WORD_W-1:0] data,
   input  logic [LAT_AW-1:0] rd_idx,
   output logic [7:0]        rd_data
);
   logic [7:0] mem_q [LATCH_BYTES];

   generate
      if (RESET_CONTENTS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int e = 0; e < LATCH_BYTES; e++) mem_q[e] <= '0;
            end else if (clr) begin
               for (int e = 0; e < LATCH_BYTES; e++) mem_q[e] <= '0;
            end else begin
               for (int l = 0; l < LANES; l++)
                  if (lane_en[l]) mem_q[LAT_AW'(pos + LAT_AW'(l))] <= data[8*l +: 8];
            end
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (clr) begin
               for (int e = 0; e < LATCH_BYTES; e++) mem_q[e] <= '0;
            end else begin
               for (int l = 0; l < LANES; l++)
                  if (lane_en[l]) mem_q[LAT_AW'(pos + LAT_AW'(l))] <= data[8*l +: 8];
            end
         end
      end
   endgenerate

   assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/flash_latch_loader.sv
module flash_latch_loader
   import fll_pkg::*;
#(
   parameter int          LATCH_BYTES    = 64,
   parameter int          N_MACRO        = 2,
   parameter logic [15:0] OPCODE         = 16'h0004,
   parameter logic [7:0]  KEY_LO         = 8'hB6,
   parameter logic [7:0]  KEY_HI         = 8'hD7,
   parameter bit          RESET_CONTENTS = 1'b1
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         reg_wr_en,
   input  logic                                         reg_wr_sel,
   input  logic [31:0]                                  reg_wr_data,
   output logic [31:0]                                  arg_q,
   output logic [31:0]                                  req_q,
   output logic                                         busy,
   output logic                                         sram_rd_en,
   output logic [31:0]                                  sram_rd_addr,
   input  logic [31:0]                                  sram_rd_data,
   input  logic                                         latch_clr,
   input  logic [$clog2(LATCH_BYTES)-1:0]               latch_rd_idx,
   output logic [7:0]                                   latch_rd_data,
   output logic [((N_MACRO > 1) ? $clog2(N_MACRO) : 1)-1:0] latch_macro
);
   localparam int LAT_AW = $clog2(LATCH_BYTES);
   localparam int MSEL_W = (N_MACRO > 1) ? $clog2(N_MACRO) : 1;

   generate
      if (LATCH_BYTES < 4 || LATCH_BYTES > 256 || (1 << LAT_AW) != LATCH_BYTES) begin : g_bad_size
         $error("LATCH_BYTES must be a power of two from 4 to 256");
      end
      if (N_MACRO < 1 || N_MACRO > 256) begin : g_bad_macro
         $error("N_MACRO must be from 1 to 256");
      end
   endgenerate

   logic              start, done, ok;
   logic [15:0]       opcode;
   logic [3:0]        code;
   logic [LANES-1:0]  lane_en;
   logic [LAT_AW-1:0] wr_pos;
   logic [31:0]       wr_data;
   logic [MSEL_W-1:0] macro_sel;

   fll_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_sel    (reg_wr_sel),
      .wr_data   (reg_wr_data),
      .busy      (busy),
      .done      (done),
      .done_code (code),
      .arg_q     (arg_q),
      .req_q     (req_q),
      .start_o   (start),
      .opcode_o  (opcode)
   );

   fll_seq #(
      .LATCH_BYTES (LATCH_BYTES),
      .N_MACRO     (N_MACRO),
      .OPCODE      (OPCODE),
      .KEY_LO      (KEY_LO),
      .KEY_HI      (KEY_HI)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .opcode_i  (opcode),
      .base_i    (arg_q),
      .rd_en_o   (sram_rd_en),
      .rd_addr_o (sram_rd_addr),
      .rd_data_i (sram_rd_data),
      .wr_lane_o (lane_en),
      .wr_pos_o  (wr_pos),
      .wr_data_o (wr_data),
      .done_o    (done),
      .code_o    (code),
      .ok_o      (ok),
      .macro_o   (macro_sel),
      .busy_o    (busy)
   );

   fll_latch #(
      .LATCH_BYTES    (LATCH_BYTES),
      .RESET_CONTENTS (RESET_CONTENTS)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (latch_clr),
      .lane_en (lane_en),
      .pos     (wr_pos),
      .data    (wr_data),
      .rd_idx  (latch_rd_idx),
      .rd_data (latch_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  latch_macro <= '0;
      else if (ok) latch_macro <= macro_sel;
   end
endmodule

// File: rtl/fll_checker.sv
module fll_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        sram_rd_en,
   input logic [31:0] sram_rd_addr,
   input logic [31:0] arg_q,
   input logic [31:0] req_q,
   input logic        reg_wr_en,
   input logic        reg_wr_sel,
   input logic [31:0] reg_wr_data,
   input logic        latch_clr,
   input logic [7:0]  latch_rd_data
);
   p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_sel && reg_wr_data[31] && !busy) |=> busy);

   p_status_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (arg_q[31:28] inside {4'hA, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5}));

   p_call_bit_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !req_q[31]);

   p_arg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(arg_q));

   p_clear_zeroes_r11: assert property (@(posedge clk) disable iff (!rst_n)
      latch_clr |=> (latch_rd_data == 8'h00));

   p_read_in_call_r13: assert property (@(posedge clk) disable iff (!rst_n)
      sram_rd_en |-> (busy && sram_rd_addr[1:0] == 2'b00));
endmodule

bind flash_latch_loader fll_checker u_fll_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .sram_rd_en    (sram_rd_en),
   .sram_rd_addr  (sram_rd_addr),
   .arg_q         (arg_q),
   .req_q         (req_q),
   .reg_wr_en     (reg_wr_en),
   .reg_wr_sel    (reg_wr_sel),
   .reg_wr_data   (reg_wr_data),
   .latch_clr     (latch_clr),
   .latch_rd_data (latch_rd_data)
);

// File: tb/flash_latch_loader_tb_top.sv
module flash_latch_loader_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] arg_q, req_q;
   logic        busy, sram_rd_en;
   logic [31:0] sram_rd_addr;
   logic [31:0] sram_rd_data = '0;
   logic        latch_clr = 1'b0;
   logic [5:0]  latch_rd_idx = '0;
   logic [7:0]  latch_rd_data;
   logic [0:0]  latch_macro;

   always #4 clk = ~clk;

   flash_latch_loader dut_i (.*);

   logic [31:0] mem [256];
   always @(posedge clk) if (sram_rd_en) sram_rd_data <= mem[sram_rd_addr[9:2]];

   int vectors = 0, fails = 0, rdcnt = 0, cycles = 0;
   always @(posedge clk) if (sram_rd_en) rdcnt++;

   // behavioural reference model
   int          m_cnt = 0;
   logic [31:0] m_arg = '0, m_req = '0, p_arg;
   logic [7:0]  m_latch [64];
   logic        m_macro = 1'b0, p_ok, p_macro;
   int          p_base, p_off, p_n;

   function automatic logic [7:0] mbyte(int addr);
      logic [31:0] w = mem[(addr >> 2) & 255];
      return w[8*(addr%4) +: 8];
   endfunction

   task automatic model_start(logic [31:0] req);
      logic [31:0] h0, h1;
      int off, n;
      p_ok = 1'b0;
      if (req[15:0] != 16'h0004) begin m_cnt = 1; p_arg = 32'h1000_0000; return; end
      if (m_arg[1:0] != 2'b00)   begin m_cnt = 1; p_arg = 32'h3000_0000; return; end
      h0 = mem[(m_arg >> 2) & 255];
      h1 = mem[((m_arg >> 2) + 1) & 255];
      off = int'(h0[23:16]);
      n = int'(h1[7:0]) + 1;
      m_cnt = 3;
      if (h0[7:0] != 8'hB6 || h0[15:8] != 8'hD7) p_arg = 32'h2000_0000;
      else if (h0[31:24] > 8'd1)                 p_arg = 32'h4000_0000;
      else if (off + n > 64)                     p_arg = 32'h5000_0000;
      else begin
         p_arg = 32'hA000_0000; p_ok = 1'b1; m_cnt = 4 + (n + 3) / 4;
         p_base = int'(m_arg) + 8; p_off = off; p_n = n; p_macro = h0[24];
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_arg = '0; m_req = '0; m_macro = 1'b0;
         for (int i = 0; i < 64; i++) m_latch[i] = 8'h00;
      end else begin
         if (latch_clr) for (int i = 0; i < 64; i++) m_latch[i] = 8'h00;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_arg = p_arg; m_req[31] = 1'b0;
               if (p_ok) begin
                  m_macro = p_macro;
                  for (int k = 0; k < p_n; k++) m_latch[p_off + k] = mbyte(p_base + k);
               end
            end
         end else if (reg_wr_en) begin
            if (reg_wr_sel) begin
               m_req = reg_wr_data;
               if (reg_wr_data[31]) model_start(reg_wr_data);
            end else m_arg = reg_wr_data;
         end
      end
   end

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
      end
   endtask

   // compared on every clock
   always @(negedge clk) if (rst_n) begin
      chk(busy == (m_cnt > 0), "R12 busy", 32'(busy), 32'(m_cnt > 0));
      chk(arg_q == m_arg, "R8 arg", arg_q, m_arg);
      chk(req_q == m_req, "R9 req", req_q, m_req);
      chk(latch_macro == m_macro, "R5 macro", 32'(latch_macro), 32'(m_macro));
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic sw_write(logic sel, logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic sweep(string tag);
      for (int i = 0; i < 64; i++) begin
         latch_rd_idx = 6'(i);
         #1;
         chk(latch_rd_data == m_latch[i], tag, 32'(latch_rd_data), 32'(m_latch[i]));
      end
   endtask

   task automatic put_block(int base, logic [7:0] k0, logic [7:0] k1, logic [7:0] off,
                            logic [7:0] mac, logic [7:0] sz, logic [7:0] seed);
      mem[(base >> 2) & 255]       = {mac, off, k1, k0};
      mem[((base >> 2) + 1) & 255] = {24'hC3A5F0, sz};
      for (int j = 0; j < 16; j++)
         mem[((base >> 2) + 2 + j) & 255] = {seed + 8'(4*j+3), seed + 8'(4*j+2),
                                              seed + 8'(4*j+1), seed + 8'(4*j)};
   endtask

   task automatic run_call(logic [31:0] base, logic [15:0] opc, logic [3:0] exp_code,
                           int exp_reads, string tag, bit poke);
      sw_write(1'b0, base);
      rdcnt = 0;
      sw_write(1'b1, 32'h8000_0000 | 32'(opc));
      chk(busy == 1'b1, "R1 start", 32'(busy), 32'h1);
      if (poke) begin
         sw_write(1'b0, 32'hDEAD_BEE0);   // R10: ignored while busy
         sw_write(1'b1, 32'h8000_0005);
      end
      while (busy) @(negedge clk);
      chk(arg_q[31:28] == exp_code, tag, 32'(arg_q[31:28]), 32'(exp_code));
      chk(rdcnt == exp_reads, "R13 reads", 32'(rdcnt), 32'(exp_reads));
      sweep("R7 latch");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(busy == 1'b0 && arg_q == 0 && req_q == 0, "R12 reset", {busy, arg_q[30:0]}, 0);
      sweep("R11 reset latch");
      // full 64-byte load, with register writes during the call (R10)
      put_block(32'h040, 8'hB6, 8'hD7, 8'd0, 8'd0, 8'h3F, 8'h10);
      run_call(32'h040, 16'h0004, 4'hA, 18, "R7 full load", 1'b1);
      // partial overwrite, macro 1 (R5), persistence of other bytes (R11)
      put_block(32'h100, 8'hB6, 8'hD7, 8'd5, 8'd1, 8'd6, 8'h80);
      run_call(32'h100, 16'h0004, 4'hA, 4, "R5 macro1 load", 1'b0);
      // range edge R6
      put_block(32'h200, 8'hB6, 8'hD7, 8'd60, 8'd0, 8'd3, 8'hC0);
      run_call(32'h200, 16'h0004, 4'hA, 3, "R6 edge ok", 1'b0);
      put_block(32'h200, 8'hB6, 8'hD7, 8'd61, 8'd0, 8'd3, 8'h50);
      run_call(32'h200, 16'h0004, 4'h5, 2, "R6 range fail", 1'b0);
      put_block(32'h200, 8'hB6, 8'hD7, 8'd0, 8'd0, 8'h80, 8'h50);
      run_call(32'h200, 16'h0004, 4'h5, 2, "R6 big size", 1'b0);
      // keys R4
      put_block(32'h300, 8'hB7, 8'hD7, 8'd0, 8'd0, 8'd3, 8'h20);
      run_call(32'h300, 16'h0004, 4'h2, 2, "R4 key lo", 1'b0);
      put_block(32'h300, 8'hB6, 8'h57, 8'd0, 8'd0, 8'd3, 8'h20);
      run_call(32'h300, 16'h0004, 4'h2, 2, "R4 key hi", 1'b0);
      // macro R5 and priority R6
      put_block(32'h300, 8'hB6, 8'hD7, 8'd0, 8'd2, 8'd3, 8'h20);
      run_call(32'h300, 16'h0004, 4'h4, 2, "R5 macro2", 1'b0);
      put_block(32'h300, 8'h00, 8'hD7, 8'd62, 8'd7, 8'd9, 8'h20);
      run_call(32'h300, 16'h0004, 4'h2, 2, "R6 priority key", 1'b0);
      put_block(32'h300, 8'hB6, 8'hD7, 8'd62, 8'd7, 8'd9, 8'h20);
      run_call(32'h300, 16'h0004, 4'h4, 2, "R6 priority macro", 1'b0);
      // opcode R2 and alignment R3
      run_call(32'h040, 16'h0005, 4'h1, 0, "R2 opcode", 1'b0);
      run_call(32'h042, 16'h0004, 4'h3, 0, "R3 align", 1'b0);
      run_call(32'h042, 16'h0006, 4'h1, 0, "R2 before R3", 1'b0);
      // single byte at last position
      put_block(32'h380, 8'hB6, 8'hD7, 8'd63, 8'd0, 8'd0, 8'hE0);
      run_call(32'h380, 16'h0004, 4'hA, 3, "R7 one byte", 1'b0);
      // clear R11, then reload
      @(negedge clk); latch_clr = 1'b1;
      @(negedge clk); latch_clr = 1'b0;
      sweep("R11 cleared");
      put_block(32'h0C0, 8'hB6, 8'hD7, 8'd9, 8'd0, 8'd10, 8'h33);
      run_call(32'h0C0, 16'h0004, 4'hA, 5, "R7 after clear", 1'b0);
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule